// File: doc/BRIEF.md
# Staged Board Power-Up Sequencer

This block brings the board supply rails up in order after reset. It first waits for main power to be good. It then switches on the three peripheral rails (1.8 V, 3.3 V and the adjustable mezzanine rail) and waits for their power-good inputs. Next it waits for the memory-bank rail monitors. Only after that does it declare power ready. Each stage moves on only once its power-good condition has held without a break for a programmable number of clock cycles, so short glitches on a monitor never advance the sequence.

Once power is ready, the block enables the 200 MHz oscillator and hands the FPGA program line to a debounced push button. Until then the program line is held low, so the FPGA cannot configure while power is only partly up. If any power-good that the current stage depends on drops, the sequencer falls back to the idle stage on the next clock edge and starts over. The stage is exported as a 2-bit code for a status indicator.

There is no data stream here, so no valid/ready handshake applies and every pin is a plain level.

Top module: `pwr_seq_top`

## Requirements
- R1: While reset is asserted, and right after it is released, `seq_state` is 2'b00, `rail_en` is all zero, `osc_en` is 0 and `prog_b` is 0.
- R2: From idle (2'b00) the sequencer moves to 2'b01 at the clock edge on which `main_pg` has been high for STABLE_CYC consecutive edges. A high pulse shorter than that does not advance the state.
- R3: In states 2'b01, 2'b10 and 2'b11, `rail_en` is all ones. From 2'b01 the sequencer moves to 2'b10 only after `main_pg` and every bit of `rail_pg` have been high together for STABLE_CYC consecutive edges.
- R4: From 2'b10 the sequencer moves to 2'b11 only after `main_pg`, all of `rail_pg` and all of `mem_pg` have been high together for STABLE_CYC consecutive edges.
- R5: A monitored power-good that goes low sends the state to 2'b00 at the next clock edge, with `rail_en` cleared. The monitored inputs are: `main_pg` in 2'b01; `main_pg` and `rail_pg` in 2'b10; all three groups in 2'b11.
- R6: `osc_en` is 1 exactly when `seq_state` is 2'b11.
- R7: `prog_b` is 0 in every state other than 2'b11. In 2'b11 it equals the debounced button level, where a released button reads 1 and a pressed button reads 0.
- R8: The button passes through a two-flop synchronizer. A new level is accepted only after the synchronized input has differed from the held level for DEB_CYC consecutive edges. A shorter press is ignored.
- R9: The state code is 2'b00 for idle, 2'b01 for peripheral rails, 2'b10 for the memory-bank rail and 2'b11 for ready, and it only ever steps forward by one or returns to 2'b00.
- R10: `adj_vsel` always carries VSEL_CODE (default 3'b010, the 1.8 V selection), in reset and in every state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| main_pg | input | 1 | Main power good |
| rail_pg | input | N_RAIL | Peripheral rail power-good inputs |
| mem_pg | input | N_MEM | Memory-bank rail power-good inputs |
| btn_raw | input | 1 | Push button, 1 = released, 0 = pressed |
| rail_en | output | N_RAIL | Peripheral rail enables |
| adj_vsel | output | VSEL_W | Adjustable rail voltage select |
| osc_en | output | 1 | 200 MHz oscillator enable |
| prog_b | output | 1 | FPGA program line, low = hold in program |
| seq_state | output | 2 | Current sequencer stage code |

## Verification
A wrong stage register shows up at the ports on the same cycle: `rail_en`, `osc_en` and `prog_b` are all decoded from the stage, so a stuck or skipped stage breaks their agreement at once. A dwell counter that is off by one moves the transition edge by one cycle, and the bench catches that by counting edges from each stimulus change. A missed loss condition leaves `seq_state` high one edge after a power-good falls. A faulty debouncer moves or drops the `prog_b` edge, which the bench checks within a few cycles of DEB_CYC.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_RAILS = 2'b01,
    ST_MEM   = 2'b10,
    ST_READY = 2'b11
  } seq_st_e;
endpackage

// File: rtl/seq_dwell.sv
// Counts consecutive cycles with cond high; done fires on the Nth.
module seq_dwell #(
  parameter int unsigned N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cond,
  output logic done
);
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1;
  localparam logic [W-1:0] LAST = W'(N - 1);

  logic [W-1:0] cnt;

  assign done = cond && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (clr || !cond || done) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int unsigned DEB_CYC = 16,
  parameter logic        RST_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_in,
  output logic btn_lvl
);
  localparam int unsigned W = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;
  localparam logic [W-1:0] LAST = W'(DEB_CYC - 1);

  logic [1:0]   sync_q;
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= {2{RST_LVL}};
    else        sync_q <= {sync_q[0], btn_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      btn_lvl <= RST_LVL;
    end else if (sync_q[1] == btn_lvl) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt     <= '0;
      btn_lvl <= sync_q[1];
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int unsigned STABLE_CYC = 8,
  parameter int unsigned N_RAIL     = 3,
  parameter int unsigned N_MEM      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              main_pg,
  input  logic [N_RAIL-1:0] rail_pg,
  input  logic [N_MEM-1:0]  mem_pg,
  output seq_st_e           state
);
  seq_st_e state_nx;
  logic    ok_main, ok_rails, ok_all;
  logic    cond, done, clr;

  assign ok_main  = main_pg;
  assign ok_rails = ok_main && (&rail_pg);
  assign ok_all   = ok_rails && (&mem_pg);

  // Condition that must dwell before leaving the current stage.
  always_comb begin
    unique case (state)
      ST_IDLE:  cond = ok_main;
      ST_RAILS: cond = ok_rails;
      ST_MEM:   cond = ok_all;
      default:  cond = 1'b0;
    endcase
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (done) state_nx = ST_RAILS;
      ST_RAILS: if (!ok_main) state_nx = ST_IDLE;
                else if (done) state_nx = ST_MEM;
      ST_MEM:   if (!ok_rails) state_nx = ST_IDLE;
                else if (done) state_nx = ST_READY;
      default:  if (!ok_all) state_nx = ST_IDLE;
    endcase
  end

  assign clr = (state_nx != state);

  seq_dwell #(.N(STABLE_CYC)) u_dwell (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .cond (cond),
    .done (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int unsigned       STABLE_CYC = 1000,
  parameter int unsigned       DEB_CYC    = 1000000,
  parameter int unsigned       N_RAIL     = 3,
  parameter int unsigned       N_MEM      = 2,
  parameter int unsigned       VSEL_W     = 3,
  parameter logic [VSEL_W-1:0] VSEL_CODE  = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              main_pg,
  input  logic [N_RAIL-1:0] rail_pg,
  input  logic [N_MEM-1:0]  mem_pg,
  input  logic              btn_raw,
  output logic [N_RAIL-1:0] rail_en,
  output logic [VSEL_W-1:0] adj_vsel,
  output logic              osc_en,
  output logic              prog_b,
  output logic [1:0]        seq_state
);
  seq_st_e st;
  logic    btn_lvl;
  logic    powered;

  seq_fsm #(
    .STABLE_CYC(STABLE_CYC),
    .N_RAIL    (N_RAIL),
    .N_MEM     (N_MEM)
  ) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .main_pg(main_pg),
    .rail_pg(rail_pg),
    .mem_pg (mem_pg),
    .state  (st)
  );

  btn_debounce #(
    .DEB_CYC(DEB_CYC),
    .RST_LVL(1'b1)
  ) u_deb (
    .clk    (clk),
    .rst_n  (rst_n),
    .btn_in (btn_raw),
    .btn_lvl(btn_lvl)
  );

  assign powered = (st != ST_IDLE);

  for (genvar g = 0; g < N_RAIL; g++) begin : g_rail
    assign rail_en[g] = powered;
  end

  assign adj_vsel  = VSEL_CODE;
  assign osc_en    = (st == ST_READY);
  assign prog_b    = (st == ST_READY) && btn_lvl;
  assign seq_state = st;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int unsigned N_RAIL = 3,
  parameter int unsigned N_MEM  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              main_pg,
  input logic [N_RAIL-1:0] rail_pg,
  input logic [N_MEM-1:0]  mem_pg,
  input logic [N_RAIL-1:0] rail_en,
  input logic              osc_en,
  input logic              prog_b,
  input logic [1:0]        seq_state
);
  a_r3_rails_on: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state != 2'b00) |-> (&rail_en));

  a_r5_rails_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 2'b00) |-> (rail_en == '0));

  a_r6_osc_ready: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en == (seq_state == 2'b11));

  a_r7_prog_held: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state != 2'b11) |-> !prog_b);

  a_r5_loss_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 2'b11 && !(main_pg && (&rail_pg) && (&mem_pg))) |=> (seq_state == 2'b00));

  a_r5_loss_rails: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 2'b01 && !main_pg) |=> (seq_state == 2'b00));

  a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state != $past(seq_state)) |-> (seq_state == 2'b00 || seq_state == $past(seq_state) + 2'b01));

  a_r2_needs_main: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seq_state) == 2'b00 && seq_state == 2'b01) |-> $past(main_pg));
endmodule

bind pwr_seq_top pwr_seq_chk #(.N_RAIL(N_RAIL), .N_MEM(N_MEM)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .main_pg  (main_pg),
  .rail_pg  (rail_pg),
  .mem_pg   (mem_pg),
  .rail_en  (rail_en),
  .osc_en   (osc_en),
  .prog_b   (prog_b),
  .seq_state(seq_state)
);

// File: tb/sim_pwr_seq_top.sv
`timescale 1ns/1ps
module sim_pwr_seq_top;
  localparam int STB = 8;
  localparam int DEB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       main_pg = 1'b0;
  logic [2:0] rail_pg = '0;
  logic [1:0] mem_pg = '0;
  logic       btn_raw = 1'b1;
  logic [2:0] rail_en;
  logic [2:0] adj_vsel;
  logic       osc_en, prog_b;
  logic [1:0] seq_state;

  int checks = 0;
  int errors = 0;
  logic [1:0] exp_q[$];
  logic [1:0] prev_st = 2'b00;
  bit done = 0;

  always #5 clk = ~clk;

  pwr_seq_top #(.STABLE_CYC(STB), .DEB_CYC(DEB)) u0 (
    .clk(clk), .rst_n(rst_n), .main_pg(main_pg), .rail_pg(rail_pg),
    .mem_pg(mem_pg), .btn_raw(btn_raw), .rail_en(rail_en),
    .adj_vsel(adj_vsel), .osc_en(osc_en), .prog_b(prog_b),
    .seq_state(seq_state)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: every change of stage must match the next expected item.
  always @(negedge clk) begin
    if (rst_n && seq_state !== prev_st) begin
      if (exp_q.size() == 0)
        chk(1'b0, "R9", "unexpected stage change", seq_state, prev_st);
      else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        chk(seq_state == e, "R9", "stage order", seq_state, e);
      end
      prev_st = seq_state;
    end
  end

  // Driver side: push the expected stage, then count edges until it appears.
  task automatic expect_step(input logic [1:0] st, input int cyc, input string req);
    int n = 0;
    exp_q.push_back(st);
    while (seq_state != st && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(n == cyc, req, "edges to stage", n, cyc);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic outs(input logic [1:0] st, input string req);
    logic [2:0] e_en;
    e_en = (st == 2'b00) ? 3'b000 : 3'b111;
    chk(seq_state == st, req, "seq_state", seq_state, st);
    chk(rail_en == e_en, req, "rail_en", rail_en, e_en);
    chk(osc_en == (st == 2'b11), "R6", "osc_en", osc_en, st == 2'b11);
    if (st != 2'b11) chk(prog_b == 1'b0, "R7", "prog_b held", prog_b, 0);
    chk(adj_vsel == 3'b010, "R10", "adj_vsel", adj_vsel, 3'b010);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    outs(2'b00, "R1");
    @(negedge clk) rst_n = 1'b1;
    idle(1);
    outs(2'b00, "R1");

    // R2: short pulse ignored, then full dwell
    idle(10);
    main_pg = 1'b1;
    idle(STB - 3);
    main_pg = 1'b0;
    idle(10);
    chk(seq_state == 2'b00, "R2", "short main pulse", seq_state, 0);
    main_pg = 1'b1;
    expect_step(2'b01, STB, "R2");
    outs(2'b01, "R3");

    // R3: two of three rails not enough
    rail_pg = 3'b011;
    idle(20);
    chk(seq_state == 2'b01, "R3", "partial rails", seq_state, 1);
    rail_pg = 3'b111;
    expect_step(2'b10, STB, "R3");
    outs(2'b10, "R4");

    // R4: memory-bank rail
    mem_pg = 2'b01;
    idle(20);
    chk(seq_state == 2'b10, "R4", "partial mem", seq_state, 2);
    mem_pg = 2'b11;
    expect_step(2'b11, STB, "R4");
    outs(2'b11, "R6");
    chk(prog_b == 1'b1, "R7", "prog_b released", prog_b, 1);

    // R8: glitch ignored, held press accepted
    btn_raw = 1'b0;
    idle(5);
    btn_raw = 1'b1;
    idle(DEB + 6);
    chk(prog_b == 1'b1, "R8", "glitch ignored", prog_b, 1);
    btn_raw = 1'b0;
    idle(DEB + 1);
    chk(prog_b == 1'b1, "R8", "not yet accepted", prog_b, 1);
    idle(2);
    chk(prog_b == 1'b0, "R8", "press accepted", prog_b, 0);
    chk(osc_en == 1'b1, "R6", "osc during press", osc_en, 1);
    btn_raw = 1'b1;
    idle(DEB + 4);
    chk(prog_b == 1'b1, "R7", "release follows", prog_b, 1);

    // R5: memory power-good loss in ready
    mem_pg = 2'b10;
    expect_step(2'b00, 1, "R5");
    outs(2'b00, "R5");

    // Restart with all rails good
    mem_pg = 2'b11;
    expect_step(2'b01, STB, "R2");
    expect_step(2'b10, STB, "R3");
    expect_step(2'b11, STB, "R4");

    // R5: peripheral loss in ready
    rail_pg = 3'b101;
    expect_step(2'b00, 1, "R5");
    rail_pg = 3'b111;
    expect_step(2'b01, STB, "R2");
    expect_step(2'b10, STB, "R3");

    // R5: peripheral loss in memory stage
    exp_q.push_back(2'b00);
    rail_pg = 3'b110;
    idle(1);
    chk(seq_state == 2'b00, "R5", "loss in mem stage", seq_state, 0);
    rail_pg = 3'b000;
    expect_step(2'b01, STB, "R2");

    // R5: main loss in rails stage
    main_pg = 1'b0;
    expect_step(2'b00, 1, "R5");
    outs(2'b00, "R5");

    idle(5);
    chk(exp_q.size() == 0, "R9", "pending stages", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule